// File: doc/BRIEF.md
# Keyed Shutdown and Wake-up Controller

This block runs from an always-on slow clock and drives the power-down output `shdw`. While `shdw` is high, the rest of the system is meant to be powered off. Software can raise `shdw` only through a command write that carries the 8-bit password 0xA5 and a set power-off bit. Any other password makes the write do nothing.

Four sources bring the system back up. There are `NPIN` wake-up pins, each with its own selectable transition and a debounce time in units of 16 slow clocks. There is the rising edge of an alarm input, which counts only when enabled. There is a forced-wake pin, active low. The forced-wake pin gates `shdw` off directly, so it works even when the slow clock has stopped. Every wake-up event sets a per-source status flag, and reading the status clears those flags. An event that arrives while the system is already up is only logged.

The wake pins, the alarm and the forced-wake pin pass through two-stage synchronisers before the logic uses them. The configuration word has this layout for the default `NPIN`=2 and `CNT_W`=4:
- bits [1:0] hold the transition mode for pin 0, and bits [3:2] hold it for pin 1;
- bits [7:4] hold the debounce count N0, and bits [11:8] hold N1;
- bit 12 enables the alarm.

The status bits are:
- [0]: pin 0;
- [1]: pin 1;
- [2]: alarm;
- [3]: forced wake.

Top module: `pwrdn_wake_ctrl`

## Requirements
- R1: After reset, `shdw` is 0, `stat_q` is 0, and `mode_q` reads 0x000F: both pins set to any-change, both counts 0, alarm disabled.
- R2: A `cmd_wr` cycle with `cmd_key` equal to 0xA5 and `cmd_off`=1 sets `shdw` at the next clock edge. Any other key, or `cmd_off`=0, leaves `shdw` unchanged.
- R3: A pin's mode field selects which transitions of that pin qualify: 00 means none, 01 means low-to-high, 10 means high-to-low, 11 means either.
- R4: With debounce count N, a qualifying transition held for 16·N cycles makes `shdw` fall at the (16·N+3)-th rising edge after the pin changes. That edge is 16·N+1 edges after the synchronised pin changes. The pin's status bit is set at the same edge.
- R5: If the pin leaves the new level before the debounce completes, no event is raised, and the next qualifying transition starts a full count again.
- R6: With bit 12 set, a rising edge on `alarm_in` clears `shdw` and sets status bit 2 at the third rising edge after it. With bit 12 clear, the alarm changes neither `shdw` nor the status.
- R7: `fwake_n`=0 forces the `shdw` output low at once, without a clock edge. The internal shutdown state and status bit 3 follow at the third rising edge, so `shdw` stays low after `fwake_n` returns high.
- R8: `stat_rd` clears all status flags at the next edge. A flag whose event lands in that same cycle stays set.
- R9: A wake-up event while `shdw` is 0 sets its status flag and has no other effect.
- R10: If a valid shutdown command and a wake-up event fall in the same cycle, the wake-up wins and `shdw` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_key | input | 8 | Password carried with the command |
| cmd_off | input | 1 | Power-off request bit of the command |
| mode_wr | input | 1 | Configuration write strobe |
| mode_wdata | input | NPIN*(2+CNT_W)+1 | Configuration word to write |
| mode_q | output | NPIN*(2+CNT_W)+1 | Current configuration word |
| stat_rd | input | 1 | Status read strobe (clears flags) |
| stat_q | output | NPIN+2 | Wake-up status flags |
| wk_pin | input | NPIN | Wake-up pins |
| alarm_in | input | 1 | Alarm input from the real-time timer |
| fwake_n | input | 1 | Forced wake-up pin, active low |
| shdw | output | 1 | Power-down output, high = system off |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a status read and the setting of a flag. The second pair is a valid shutdown command and a wake-up event. The bench counts edges from an alarm rising edge and raises `stat_rd` exactly in the cycle in which the alarm event is decoded. It then expects the alarm flag to survive the clear, and a second read to empty the status. It repeats the same timing with a valid command in place of the read and expects `shdw` to stay 0. A later plain command must still power the system down.

// File: rtl/pwrdn_pkg.sv
// Shared constants and types for the keyed shutdown / wake-up controller.
package pwrdn_pkg;
    // Password that a shutdown command must carry.
    localparam logic [7:0] KEY_VAL = 8'hA5;

    // Per-pin transition selection; bit 0 = rising, bit 1 = falling.
    typedef enum logic [1:0] {
        DET_NONE = 2'b00,
        DET_RISE = 2'b01,
        DET_FALL = 2'b10,
        DET_ANY  = 2'b11
    } det_mode_e;
endpackage

// File: rtl/pwk_sync.sv
// Two-stage resynchroniser for a vector of asynchronous inputs.
// Assumes each bit is an independent level signal; reset loads RST_VAL
// into both stages so that a quiet input produces no edge after reset.
module pwk_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift the inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pwk_pin_qual.sv
// Transition detector with debounce for one wake-up pin.
// Assumes lvl is already synchronised. A transition selected by mode arms a
// down-counter of 16*count-1; the event fires when the counter reaches zero
// while the pin still holds the new level. count = 0 fires on the transition.
// Leaving the level disarms the counter; the next qualifying transition
// restarts it from the full value.
module pwk_pin_qual #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] count,
    output logic             ev
);
    localparam int REM_W = CNT_W + 4;

    logic             prev;
    logic             armed;
    logic             target;
    logic [REM_W-1:0] rem;
    logic             qual;

    // Decide whether this cycle's transition is one that mode selects.
    always_comb begin
        qual = (mode[0] & lvl & ~prev) | (mode[1] & ~lvl & prev);
        ev   = (qual && count == '0) ||
               (armed && lvl == target && rem == '0 && mode != 2'b00);
    end

    // Track the previous level and run the debounce counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev   <= 1'b0;
            armed  <= 1'b0;
            target <= 1'b0;
            rem    <= '0;
        end else begin
            prev <= lvl;
            if (qual) begin
                armed  <= (count != '0);
                target <= lvl;
                rem    <= {count, 4'h0} - REM_W'(1);
            end else if (armed) begin
                if (lvl != target || rem == '0 || mode == 2'b00)
                    armed <= 1'b0;
                else
                    rem <= rem - REM_W'(1);
            end
        end
    end
endmodule

// File: rtl/pwrdn_wake_ctrl.sv
// Keyed shutdown and wake-up controller.
// Assumes clk is the always-on slow clock and every pin input is asynchronous.
// shdw is the registered shutdown state gated by fwake_n, so a forced wake-up
// takes effect even when clk is stopped. A wake event always beats a
// shutdown command in the same cycle.
module pwrdn_wake_ctrl #(
    parameter int   NPIN   = 2,
    parameter int   CNT_W  = 4,
    localparam int  MODE_W = NPIN * (2 + CNT_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [7:0]        cmd_key,
    input  logic              cmd_off,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic [MODE_W-1:0] mode_q,
    input  logic              stat_rd,
    output logic [NPIN+1:0]   stat_q,
    input  logic [NPIN-1:0]   wk_pin,
    input  logic              alarm_in,
    input  logic              fwake_n,
    output logic              shdw
);
    import pwrdn_pkg::*;

    localparam int SRC_W = NPIN + 2;
    localparam int CNT_LO = 2 * NPIN;
    localparam logic [MODE_W-1:0] MODE_RST =
        {{(MODE_W - 2 * NPIN){1'b0}}, {(2 * NPIN){1'b1}}};
    localparam logic [SRC_W-1:0] SYNC_RST = {1'b1, 1'b0, {NPIN{1'b0}}};

    logic [SRC_W-1:0] sy;
    logic             alm_prev;
    logic [SRC_W-1:0] wake_ev;
    logic             cmd_ok;
    logic             shdw_q;

    // Resynchronise pins, alarm and forced-wake.
    pwk_sync #(.W(SRC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({fwake_n, alarm_in, wk_pin}),
        .q     (sy)
    );

    // One qualifier per wake-up pin.
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        pwk_pin_qual #(.CNT_W(CNT_W)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (sy[i]),
            .mode  (mode_q[2*i +: 2]),
            .count (mode_q[CNT_LO + i*CNT_W +: CNT_W]),
            .ev    (wake_ev[i])
        );
    end

    // Alarm edge, forced-wake level and password check.
    always_comb begin
        wake_ev[NPIN]   = mode_q[MODE_W-1] & sy[NPIN] & ~alm_prev;
        wake_ev[NPIN+1] = ~sy[NPIN+1];
        cmd_ok          = cmd_wr && (cmd_key == KEY_VAL) && cmd_off;
        shdw            = shdw_q & fwake_n;
    end

    // Alarm history, configuration, shutdown state and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_prev <= 1'b0;
            mode_q   <= MODE_RST;
            shdw_q   <= 1'b0;
            stat_q   <= '0;
        end else begin
            alm_prev <= sy[NPIN];
            if (mode_wr)
                mode_q <= mode_wdata;
            if (|wake_ev)
                shdw_q <= 1'b0;
            else if (cmd_ok)
                shdw_q <= 1'b1;
            stat_q <= (stat_rd ? '0 : stat_q) | wake_ev;
        end
    end
endmodule

// File: rtl/pwrdn_wake_ctrl_chk.sv
// Checker for pwrdn_wake_ctrl; relates commands, events, state and status.
module pwrdn_wake_ctrl_chk #(
    parameter int NPIN = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_wr,
    input logic [7:0]      cmd_key,
    input logic            cmd_off,
    input logic            stat_rd,
    input logic [NPIN+1:0] stat_q,
    input logic            shdw_q,
    input logic [NPIN+1:0] ev,
    input logic            fw_s
);
    import pwrdn_pkg::*;

    a_r2_set_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shdw_q) |-> $past(cmd_wr && cmd_key == KEY_VAL && cmd_off));

    a_r2_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_key != KEY_VAL && !shdw_q) |=> !shdw_q);

    a_r4_release_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shdw_q) |-> $past(|ev));

    a_r7_forced_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !fw_s |=> stat_q[NPIN+1]);

    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ev == '0) |=> stat_q == '0);

    a_r8_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((stat_q & $past(ev)) == $past(ev)));

    a_r10_wake_beats_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> !shdw_q);
endmodule

bind pwrdn_wake_ctrl pwrdn_wake_ctrl_chk #(.NPIN(NPIN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_wr  (cmd_wr),
    .cmd_key (cmd_key),
    .cmd_off (cmd_off),
    .stat_rd (stat_rd),
    .stat_q  (stat_q),
    .shdw_q  (shdw_q),
    .ev      (wake_ev),
    .fw_s    (sy[NPIN+1])
);

// File: tb/pwrdn_wake_ctrl_test.sv
module pwrdn_wake_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_key = 8'h00;
    logic        cmd_off = 1'b0;
    logic        mode_wr = 1'b0;
    logic [12:0] mode_wdata = '0;
    logic [12:0] mode_q;
    logic        stat_rd = 1'b0;
    logic [3:0]  stat_q;
    logic [1:0]  wk_pin = 2'b00;
    logic        alarm_in = 1'b0;
    logic        fwake_n = 1'b1;
    logic        shdw;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwrdn_wake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_key(cmd_key),
        .cmd_off(cmd_off), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .mode_q(mode_q), .stat_rd(stat_rd), .stat_q(stat_q), .wk_pin(wk_pin),
        .alarm_in(alarm_in), .fwake_n(fwake_n), .shdw(shdw)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance n rising edges, then settle at the following falling edge.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic shut();
        cmd_wr = 1'b1; cmd_key = 8'hA5; cmd_off = 1'b1;
        tick(1);
        cmd_wr = 1'b0;
    endtask

    task automatic rdclr();
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
    endtask

    task automatic setmode(input logic [12:0] v);
        mode_wr = 1'b1; mode_wdata = v;
        tick(1);
        mode_wr = 1'b0;
    endtask

    function automatic bit qualifies(input logic [1:0] m, input bit o, input bit n);
        return (o != n) && ((n && m[0]) || (!n && m[1]));
    endfunction

    function automatic int edges_before_release(input int n);
        return 16 * n + 2;
    endfunction

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED);
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk(shdw == 1'b0, "R1 shdw", shdw, 0);
        chk(stat_q == 4'h0, "R1 status", stat_q, 0);
        chk(mode_q == 13'h000F, "R1 mode", mode_q, 13'h000F);

        // R2 wrong keys and cleared off bit
        for (int i = 0; i < 8; i++) begin
            logic [7:0] k;
            k = 8'($urandom);
            if (k == 8'hA5) k = 8'h5A;
            cmd_wr = 1'b1; cmd_key = k; cmd_off = 1'b1;
            tick(1);
            cmd_wr = 1'b0;
            chk(shdw == 1'b0, "R2 bad key", shdw, 0);
        end
        cmd_wr = 1'b1; cmd_key = 8'hA5; cmd_off = 1'b0;
        tick(1);
        cmd_wr = 1'b0;
        chk(shdw == 1'b0, "R2 off bit clear", shdw, 0);
        shut();
        chk(shdw == 1'b1, "R2 valid key", shdw, 1);

        // R3/R4 random modes and debounce counts on pin 0
        for (int t = 0; t < 14; t++) begin
            logic [1:0] m;
            int n;
            bit o, q;
            m = 2'($urandom % 4);
            n = $urandom % 3;
            shut();
            rdclr();
            setmode(13'((n << 4) | m));
            o = wk_pin[0];
            q = qualifies(m, o, !o);
            wk_pin[0] = !o;
            tick(edges_before_release(n));
            chk(shdw == 1'b1, "R4 held until count done", shdw, 1);
            tick(1);
            chk(shdw == !q, "R3 mode selects transition", shdw, !q);
            chk(stat_q[0] == q, "R4 pin flag", stat_q[0], q);
            tick(3);
        end

        // R5 level lost before the count completes
        setmode(13'h000);
        wk_pin[0] = 1'b0;
        tick(4);
        setmode(13'h011);
        shut();
        rdclr();
        wk_pin[0] = 1'b1;
        tick(8);
        wk_pin[0] = 1'b0;
        tick(40);
        chk(shdw == 1'b1, "R5 no event on short pulse", shdw, 1);
        chk(stat_q == 4'h0, "R5 no flag on short pulse", stat_q, 0);
        wk_pin[0] = 1'b1;
        tick(edges_before_release(1));
        chk(shdw == 1'b1, "R5 full count restarted", shdw, 1);
        tick(1);
        chk(shdw == 1'b0, "R5 release after full count", shdw, 0);

        // R6 alarm disabled, then enabled
        setmode(13'h000);
        shut();
        rdclr();
        alarm_in = 1'b1;
        tick(6);
        chk(shdw == 1'b1, "R6 disabled alarm ignored", shdw, 1);
        chk(stat_q[2] == 1'b0, "R6 disabled alarm no flag", stat_q[2], 0);
        alarm_in = 1'b0;
        tick(3);
        setmode(13'h1000);
        alarm_in = 1'b1;
        tick(2);
        chk(shdw == 1'b1, "R6 alarm before third edge", shdw, 1);
        tick(1);
        chk(shdw == 1'b0, "R6 alarm releases", shdw, 0);
        chk(stat_q[2] == 1'b1, "R6 alarm flag", stat_q[2], 1);
        alarm_in = 1'b0;
        tick(3);

        // R7 forced wake without clock edge
        shut();
        rdclr();
        fwake_n = 1'b0;
        #1;
        chk(shdw == 1'b0, "R7 immediate release", shdw, 0);
        tick(2);
        chk(stat_q[3] == 1'b0, "R7 flag waits for sync", stat_q[3], 0);
        tick(1);
        chk(stat_q[3] == 1'b1, "R7 flag after sync", stat_q[3], 1);
        fwake_n = 1'b1;
        tick(4);
        chk(shdw == 1'b0, "R7 stays released", shdw, 0);

        // R8 read clears; set in same cycle wins
        rdclr();
        chk(stat_q == 4'h0, "R8 read clears", stat_q, 0);
        alarm_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
        chk(stat_q[2] == 1'b1, "R8 set beats clear", stat_q[2], 1);
        rdclr();
        chk(stat_q == 4'h0, "R8 second read clears", stat_q, 0);
        alarm_in = 1'b0;
        tick(3);

        // R9 event while up only logs
        setmode(13'h003);
        wk_pin[0] = !wk_pin[0];
        tick(4);
        chk(stat_q[0] == 1'b1, "R9 event logged", stat_q[0], 1);
        chk(shdw == 1'b0, "R9 no other effect", shdw, 0);

        // R10 wake event and valid command in the same cycle
        setmode(13'h1000);
        alarm_in = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_key = 8'hA5; cmd_off = 1'b1;
        tick(1);
        cmd_wr = 1'b0;
        chk(shdw == 1'b0, "R10 wake beats command", shdw, 0);
        chk(stat_q[2] == 1'b1, "R10 alarm logged", stat_q[2], 1);
        shut();
        chk(shdw == 1'b1, "R10 later command works", shdw, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule